// File: doc/BRIEF.md
# Single-Request Interrupt Concentrator

This block folds 64 level-sensitive interrupt lines into one interrupt request. Lines 0 to 31 come from PCI slots. Each group of four PCI lines shares one map register, so line n uses register n>>2. Lines 32 to 63 come from on-board I/O sources, and each of them has its own map register: line n uses register n-32.

Bit 31 of every map register is an enable. The lower 31 bits are fixed identification values that software can only read. Only one request is outstanding at any time. Software ends a request by writing an acknowledge word that names it. The block then picks the next line that is asserted and enabled.

Register accesses are 32-bit and single-cycle, with a 16-bit byte address. Only the word with address bit 2 set holds data. Reads have no side effects. The request appears as a 6-bit vector number with a valid flag. Both are registered and change at the clock edge that samples the condition.

Top module: `irq_concentrator`

## Requirements
- R1: A line can raise a request only while the enable bit of its own map register is set. PCI line n uses map n>>2. On-board line n uses map n-32.
- R2: A map write changes only bit 31. Bits 30:0 read back as constants: PCI map i holds 0x7C0|(i<<2), and on-board map i holds 0x7E0+i.
- R3: While a request is valid, it is held. New on-board assertions do not replace it, and neither do map enables set by software.
- R4: With no request valid, the lowest-indexed line that is both asserted and enabled becomes the request at the next clock edge. Every PCI line therefore wins over every on-board line.
- R5: An acknowledge write at 0x1404+k·32 (k = 0..7) drops the request when vector>>2 equals k. An acknowledge write at 0x1804+k·8 (k = 0..31) drops it only when the vector equals 32+k. Any other acknowledge is ignored. Selection runs again in the same cycle, so a line that is still asserted is issued again.
- R6: A map write with bit 31 = 0 to the register that gates the current request drops that request, and selection runs again in the same cycle.
- R7: The PCI maps sit at 0x0C04+i·8 and the on-board maps at 0x1004+i·8. The neighbouring word with bit 2 clear reads zero, and writes to it have no effect.
- R8: Reset clears every enable bit and the sampled-input history, and leaves no request valid.
- R9: When a line falls, the request it raised stays valid.
- R10: An enabled PCI line that rises replaces any outstanding request. If several rise together, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Level interrupt lines (0-31 PCI, 32-63 on-board) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Write data (only bit 31 is used) |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| req_valid_o | output | 1 | A request is outstanding |
| req_vec_o | output | 6 | Vector number of the outstanding request |

## Verification
The assertions are checked on every cycle. They confirm four things:
- a valid request always belongs to an enabled source;
- a request only becomes valid for a line that was asserted;
- an idle block with an asserted, enabled line issues a request at the next edge;
- without a register write or a PCI rising edge, the request holds its vector.

The bench scenarios cover what those properties cannot:
- the exact lowest-index choice;
- acknowledge index matching, which differs between the two groups;
- preemption by a PCI rising edge;
- reissue of a line that is still held after an acknowledge;
- the constant read-back values of the map registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int NUM_IN      = 64;
  parameter int NUM_PCI     = 32;
  parameter int PCI_GRP     = 4;
  parameter int NUM_PCI_MAP = NUM_PCI / PCI_GRP;
  parameter int NUM_OB      = NUM_IN - NUM_PCI;
  parameter int VEC_W       = $clog2(NUM_IN);
  parameter int IDX_W       = $clog2(NUM_OB);
  parameter int DATA_W      = 32;
  parameter int ADDR_W      = 16;
  parameter int EN_BIT      = DATA_W - 1;

  parameter logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00;
  parameter logic [ADDR_W-1:0] OB_MAP_BASE  = 16'h1000;
  parameter logic [ADDR_W-1:0] PCI_ACK_BASE = 16'h1400;
  parameter logic [ADDR_W-1:0] OB_ACK_BASE  = 16'h1800;

  // fixed low fields of the map registers
  function automatic logic [EN_BIT-1:0] pci_map_const(input logic [IDX_W-1:0] i);
    return EN_BIT'(32'h7C0 | (32'(i) << 2));
  endfunction

  function automatic logic [EN_BIT-1:0] ob_map_const(input logic [IDX_W-1:0] i);
    return EN_BIT'(32'h7E0 + 32'(i));
  endfunction
endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_IN-1:0] en_vec_o,
  output logic [NUM_IN-1:0] en_nxt_vec_o,
  output logic              pci_map_wr_o,
  output logic              ob_map_wr_o,
  output logic              new_en_o,
  output logic              pci_ack_o,
  output logic              ob_ack_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int PMAP_W = $clog2(NUM_PCI_MAP);

  logic [NUM_PCI_MAP-1:0] pci_en_q, pci_en_d;
  logic [NUM_OB-1:0]      ob_en_q, ob_en_d;
  logic data_word, pci_map_hit, ob_map_hit, pci_ack_hit, ob_ack_hit;
  logic [PMAP_W-1:0] pci_idx;
  logic [IDX_W-1:0]  ob_idx;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[EN_BIT-1:0], addr_i[1:0]};

  assign data_word   = addr_i[2];
  assign pci_map_hit = data_word && (addr_i[ADDR_W-1:6] == PCI_MAP_BASE[ADDR_W-1:6]);
  assign ob_map_hit  = data_word && (addr_i[ADDR_W-1:8] == OB_MAP_BASE[ADDR_W-1:8]);
  assign pci_ack_hit = data_word && (addr_i[ADDR_W-1:8] == PCI_ACK_BASE[ADDR_W-1:8]);
  assign ob_ack_hit  = data_word && (addr_i[ADDR_W-1:8] == OB_ACK_BASE[ADDR_W-1:8]);
  assign pci_idx     = addr_i[3 +: PMAP_W];
  assign ob_idx      = addr_i[3 +: IDX_W];

  assign pci_map_wr_o = wr_i && pci_map_hit;
  assign ob_map_wr_o  = wr_i && ob_map_hit;
  assign pci_ack_o    = wr_i && pci_ack_hit;
  assign ob_ack_o     = wr_i && ob_ack_hit;
  assign new_en_o     = wdata_i[EN_BIT];

  always_comb begin
    idx_o = '0;
    if (pci_map_hit)      idx_o = IDX_W'(pci_idx);
    else if (pci_ack_hit) idx_o = IDX_W'(addr_i[5 +: PMAP_W]);
    else                  idx_o = ob_idx;
  end

  always_comb begin
    pci_en_d = pci_en_q;
    ob_en_d  = ob_en_q;
    if (pci_map_wr_o) pci_en_d[pci_idx] = new_en_o;
    if (ob_map_wr_o)  ob_en_d[ob_idx]   = new_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_en_q <= '0;
      ob_en_q  <= '0;
    end else begin
      pci_en_q <= pci_en_d;
      ob_en_q  <= ob_en_d;
    end
  end

  // expand per-register enables to per-line gates
  for (genvar n = 0; n < NUM_IN; n++) begin : g_en
    if (n < NUM_PCI) begin : g_pci
      assign en_vec_o[n]     = pci_en_q[n / PCI_GRP];
      assign en_nxt_vec_o[n] = pci_en_d[n / PCI_GRP];
    end else begin : g_ob
      assign en_vec_o[n]     = ob_en_q[n - NUM_PCI];
      assign en_nxt_vec_o[n] = ob_en_d[n - NUM_PCI];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (pci_map_hit)     rdata_o = {pci_en_q[pci_idx], pci_map_const(IDX_W'(pci_idx))};
    else if (ob_map_hit) rdata_o = {ob_en_q[ob_idx], ob_map_const(ob_idx)};
  end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_valid_o,
  output logic [VEC_W-1:0]  req_vec_o
);
  localparam int PCI_IDX_W = $clog2(NUM_PCI);
  localparam int GRP_SH    = $clog2(PCI_GRP);
  localparam int PMAP_W    = $clog2(NUM_PCI_MAP);

  logic [NUM_IN-1:0] en_vec, en_nxt, pend_q;
  logic pci_map_wr, ob_map_wr, new_en, pci_ack, ob_ack;
  logic [IDX_W-1:0] idx;
  logic [NUM_PCI-1:0] pci_rise;
  logic rise_found, any_found, drop;
  logic [PCI_IDX_W-1:0] rise_idx;
  logic [VEC_W-1:0] any_idx;
  logic req_v_q, req_v_d;
  logic [VEC_W-1:0] req_q, req_d;
  logic req_is_ob, grp_match, vec_match;

  irqc_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .en_vec_o    (en_vec),
    .en_nxt_vec_o(en_nxt),
    .pci_map_wr_o(pci_map_wr),
    .ob_map_wr_o (ob_map_wr),
    .new_en_o    (new_en),
    .pci_ack_o   (pci_ack),
    .ob_ack_o    (ob_ack),
    .idx_o       (idx)
  );

  assign pci_rise = irq_i[NUM_PCI-1:0] & ~pend_q[NUM_PCI-1:0] & en_nxt[NUM_PCI-1:0];

  irqc_pick #(.N(NUM_PCI)) u_pick_rise (
    .req_i  (pci_rise),
    .found_o(rise_found),
    .idx_o  (rise_idx)
  );

  irqc_pick #(.N(NUM_IN)) u_pick_all (
    .req_i  (irq_i & en_nxt),
    .found_o(any_found),
    .idx_o  (any_idx)
  );

  assign req_is_ob = req_q[VEC_W-1];
  assign grp_match = !req_is_ob && (req_q[GRP_SH +: PMAP_W] == idx[PMAP_W-1:0]);
  assign vec_match = req_is_ob && (req_q[IDX_W-1:0] == idx);

  always_comb begin
    drop = 1'b0;
    if (pci_map_wr && !new_en && grp_match) drop = 1'b1;
    if (ob_map_wr  && !new_en && vec_match) drop = 1'b1;
    if (pci_ack && grp_match)               drop = 1'b1;
    if (ob_ack  && vec_match)               drop = 1'b1;

    req_v_d = req_v_q && !drop;
    req_d   = req_q;
    if (rise_found) begin
      req_v_d = 1'b1;
      req_d   = VEC_W'(rise_idx);
    end else if (!req_v_d && any_found) begin
      req_v_d = 1'b1;
      req_d   = any_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      req_v_q <= 1'b0;
      req_q   <= '0;
    end else begin
      pend_q  <= irq_i;
      req_v_q <= req_v_d;
      req_q   <= req_d;
    end
  end

  assign req_valid_o = req_v_q;
  assign req_vec_o   = req_q;
endmodule

// File: rtl/irq_concentrator_chk.sv
module irq_concentrator_chk
  import irqc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_IN-1:0] irq_i,
  input logic              reg_wr_i,
  input logic [NUM_IN-1:0] en_vec_i,
  input logic              req_valid_i,
  input logic [VEC_W-1:0]  req_vec_i
);
  logic [NUM_IN-1:0] irq_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_prev <= '0;
    else         irq_prev <= irq_i;
  end

  AST_REQ_SRC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> en_vec_i[req_vec_i]);  // R1

  AST_REQ_FROM_ASSERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_i) |-> ((($past(irq_i)) >> req_vec_i) & NUM_IN'(1)) != '0);  // R4

  AST_IDLE_ISSUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !reg_wr_i && |(irq_i & en_vec_i)) |=> req_valid_i);  // R4

  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !reg_wr_i && ((irq_i[NUM_PCI-1:0] & ~irq_prev[NUM_PCI-1:0]) == '0))
    |=> (req_valid_i && $stable(req_vec_i)));  // R3
endmodule

bind irq_concentrator irq_concentrator_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .reg_wr_i   (reg_wr_i),
  .en_vec_i   (en_vec),
  .req_valid_i(req_valid_o),
  .req_vec_i  (req_vec_o)
);

// File: tb/irq_concentrator_tb.sv
module irq_concentrator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq;
  logic        wr;
  logic [15:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rv;
  logic [5:0]  rvec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       v;
    logic [5:0] vec;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  localparam logic [31:0] EN = 32'h8000_0000;

  always #5 clk = ~clk;

  irq_concentrator u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_i      (irq),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .req_valid_o(rv),
    .req_vec_o  (rvec)
  );

  // monitor: compare registered request after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks++;
        if (rv !== e.v || (e.v && rvec !== e.vec)) begin
          errors++;
          $display("FAIL %s: got valid=%0b vec=%0d, expected valid=%0b vec=%0d",
                   e.tag, rv, rvec, e.v, e.vec);
        end
      end
    end
  end

  task automatic cyc(input logic [63:0] i, input logic w, input logic [15:0] a,
                     input logic [31:0] d, input logic ev, input logic [5:0] evec,
                     input string tag);
    @(negedge clk);
    irq = i; wr = w; addr = a; wdata = d;
    exp_q.push_back('{ev, evec, tag});
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #1;
    checks++;
    if (rdata !== expv) begin
      errors++;
      $display("FAIL %s: read %h got %h expected %h", tag, a, rdata, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rv !== 1'b0) begin
      errors++;
      $display("FAIL R8: valid during reset got %0b expected 0", rv);
    end
    rst_n = 1'b1;
  endtask

  localparam logic [63:0] B1  = 64'd1 << 1;
  localparam logic [63:0] B3  = 64'd1 << 3;
  localparam logic [63:0] B31 = 64'd1 << 31;
  localparam logic [63:0] B34 = 64'd1 << 34;
  localparam logic [63:0] B40 = 64'd1 << 40;
  localparam logic [63:0] B63 = 64'd1 << 63;

  initial begin
    rst_n = 1'b0; irq = '0; wr = 1'b0; addr = '0; wdata = '0;
    do_reset();
    rd(16'h0C04, 32'h0000_07C0, "R2 pci map0 const");
    rd(16'h0C1C, 32'h0000_07CC, "R2 pci map3 const");
    rd(16'h102C, 32'h0000_07E5, "R2 ob map5 const");
    rd(16'h0C18, 32'h0, "R7 even word reads zero");

    cyc(B3, 1'b0, 16'h0, 32'h0, 1'b0, 6'd0, "R1 disabled line gated");
    cyc(B3, 1'b1, 16'h0C04, EN, 1'b1, 6'd3, "R4 enable issues line 3");
    rd(16'h0C04, 32'h8000_07C0, "R2 enable readback");
    cyc(B3 | B40, 1'b1, 16'h1044, EN, 1'b1, 6'd3, "R3 ob line no replace");
    cyc(B3 | B40, 1'b1, 16'h1844, 32'h0, 1'b1, 6'd3, "R5 ob ack mismatch");
    cyc(B3 | B40, 1'b1, 16'h1424, 32'h0, 1'b1, 6'd3, "R5 pci ack other group");
    cyc(B40, 1'b0, 16'h0, 32'h0, 1'b1, 6'd3, "R9 fall keeps request");
    cyc(B40, 1'b1, 16'h1404, 32'h0, 1'b1, 6'd40, "R5 ack then next");
    cyc(B40 | B1, 1'b0, 16'h0, 32'h0, 1'b1, 6'd1, "R10 pci rise preempts");
    cyc(B40 | B1, 1'b1, 16'h1014, EN, 1'b1, 6'd1, "R3 enable write holds");
    cyc(B40 | B1 | B34, 1'b0, 16'h0, 32'h0, 1'b1, 6'd1, "R3 ob rise holds");
    cyc(B40 | B1 | B34, 1'b1, 16'h0C04, 32'h0, 1'b1, 6'd34, "R6 disable drops");
    cyc(B40 | B1 | B34, 1'b1, 16'h0C04, 32'hFFFF_FFFF, 1'b1, 6'd34, "R3 reenable holds");
    rd(16'h0C04, 32'h8000_07C0, "R2 low bits unwritable");
    cyc(B40 | B1 | B34, 1'b1, 16'h1814, 32'h0, 1'b1, 6'd1, "R4 pci beats ob");
    cyc(B40 | B1 | B34, 1'b1, 16'h0C00, 32'h0, 1'b1, 6'd1, "R7 even word write ignored");
    rd(16'h0C04, 32'h8000_07C0, "R7 enable unchanged");

    do_reset();
    rd(16'h0C04, 32'h0000_07C0, "R8 pci enable cleared");
    rd(16'h1044, 32'h0000_07E8, "R8 ob enable cleared");
    cyc(64'd0, 1'b1, 16'h10FC, EN, 1'b0, 6'd0, "R8 idle after reset");
    cyc(B63, 1'b0, 16'h0, 32'h0, 1'b1, 6'd63, "R1 ob own map");
    cyc(B63, 1'b1, 16'h0C3C, EN, 1'b1, 6'd63, "R3 enable group7 holds");
    cyc(B63 | B31, 1'b0, 16'h0, 32'h0, 1'b1, 6'd31, "R10 pci preempts ob");
    cyc(B63 | B31, 1'b1, 16'h14E4, 32'h0, 1'b1, 6'd31, "R5 held line reissued");
    cyc(B63, 1'b1, 16'h14E4, 32'h0, 1'b1, 6'd63, "R5 ack moves to ob");
    cyc(64'd0, 1'b1, 16'h18FC, 32'h0, 1'b0, 6'd0, "R5 ob ack empties");
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule